// File: doc/BRIEF.md
# Memory Access Interface Unit

This unit connects a processor's internal data bus to an external memory port. It holds an address register and a data register, each loaded from the internal bus by its own strobe. A read or write command starts a memory cycle: the unit raises the matching memory strobe and holds it until memory answers with a single-cycle completion pulse. How long a transfer lasts is set only by when that pulse arrives, so slow and fast memories are served by the same control sequence.

The address and data registers are independent. A controller may load them in either order or in the same cycle. While a transfer is in flight the unit reports busy, so the controller can go on with work that does not touch the two registers. Loads attempted while busy are dropped and recorded in a sticky error flag. Commands issued before the needed registers hold a value are refused with a one-cycle reject pulse. After a read, the returned word is held in the data register and appears on the data output.

Top module: `mem_access_unit`

## Requirements
- R1: After reset, busy, done, cmd_reject, load_err, mem_rd and mem_wr are all 0, and both registers count as not loaded.
- R2: While busy is 0, addr_load copies the low ADDR_W bits of bus_data into the address register and data_load copies bus_data into the data register, at the next clock edge. The two loads may come in either order or in the same cycle. mem_addr always shows the address register and mdr_data always shows the data register.
- R3: cmd_write, sampled with busy 0 and both registers loaded in an earlier cycle, makes busy and mem_wr 1 from the next cycle on, with mem_rd 0.
- R4: cmd_read, sampled with busy 0 and the address register loaded, makes busy and mem_rd 1 from the next cycle on. At the edge where mem_mfc is sampled high, the data register takes mem_rdata, and mdr_data shows it from the done cycle on. A completed read counts as loading the data register.
- R5: busy and the active strobe stay 1 through the cycle in which mem_mfc is high and drop in the following cycle, whatever the latency; with a memory that raises mem_mfc L+1 cycles after the strobe, busy is high for exactly L+2 cycles.
- R6: done is 1 for exactly one cycle, the cycle after mem_mfc was sampled while busy.
- R7: cmd_write without both registers loaded, cmd_read without the address register loaded, or cmd_read and cmd_write together while idle give cmd_reject = 1 for one cycle in the next cycle, with busy, mem_rd and mem_wr staying 0.
- R8: addr_load or data_load while busy leaves both registers unchanged and sets load_err from the next cycle on; load_err stays 1 until reset.
- R9: A command issued while busy has no effect (no reject, strobe unchanged), and mem_mfc while idle has no effect (no done, data register unchanged).
- R10: A new command is accepted in the cycle in which done is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_data | input | DATA_W | Word from the internal bus |
| addr_load | input | 1 | Load address register from bus_data |
| data_load | input | 1 | Load data register from bus_data |
| cmd_read | input | 1 | Start a memory read |
| cmd_write | input | 1 | Start a memory write |
| mem_mfc | input | 1 | Single-cycle completion pulse from memory |
| mem_rdata | input | DATA_W | Read data from memory |
| mem_addr | output | ADDR_W | Address register contents to memory |
| mdr_data | output | DATA_W | Data register contents (write data and read result) |
| mem_rd | output | 1 | Read strobe to memory |
| mem_wr | output | 1 | Write strobe to memory |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_reject | output | 1 | One-cycle pulse for a refused command |
| load_err | output | 1 | Sticky flag: a register load was attempted while busy |

## Verification
The bench varies the memory latency and counts busy cycles, so a design that finishes on a fixed timer or drops busy one cycle early or late shows a wrong count. It loads the registers in both orders and in one cycle, issues commands with a register missing or with both commands together, and checks that a design accepting them raises a strobe instead of a reject. It pokes loads and commands into the middle of a transfer and a stray completion pulse into idle time, so a design that lets them through corrupts the stored address or data, rejects wrongly, or pulses done. It also issues a read in the very done cycle of a write, catching a design that needs an extra idle cycle between transfers.

// File: rtl/mau_pkg.sv
package mau_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } mau_op_t;

  // A command is legal when exactly one of read/write is asked for, the
  // address register is loaded, and for a write the data register too.
  function automatic logic cmd_legal(input logic rd, input logic wr,
                                     input logic addr_ok, input logic data_ok);
    return (rd ^ wr) && addr_ok && (rd || data_ok);
  endfunction

  function automatic mau_op_t op_of(input logic rd, input logic wr);
    if (rd && !wr) return OP_READ;
    if (wr && !rd) return OP_WRITE;
    return OP_IDLE;
  endfunction

endpackage

// File: rtl/mau_regs.sv
module mau_regs #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              addr_load,
  input  logic              data_load,
  input  logic              busy,
  input  logic              rd_capture,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              addr_ok,
  output logic              data_ok,
  output logic              load_err
);

  logic load_blocked;
  logic addr_take;
  logic data_take;

  assign load_blocked = busy && (addr_load || data_load);
  assign addr_take    = !busy && addr_load;
  assign data_take    = !busy && data_load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      addr_ok <= 1'b0;
    end else if (addr_take) begin
      addr_q  <= bus_data[ADDR_W-1:0];
      addr_ok <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      data_ok <= 1'b0;
    end else if (rd_capture) begin
      data_q  <= mem_rdata;
      data_ok <= 1'b1;
    end else if (data_take) begin
      data_q  <= bus_data;
      data_ok <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            load_err <= 1'b0;
    else if (load_blocked) load_err <= 1'b1;
  end

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && addr_load) |=> $stable(addr_q));
  // R8
  load_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_blocked |=> load_err);
  // R4
  rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |=> (data_q == $past(mem_rdata)));
  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_take |=> (addr_q == $past(bus_data[ADDR_W-1:0])) && addr_ok);

endmodule

// File: rtl/mau_seq.sv
module mau_seq
  import mau_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_read,
  input  logic cmd_write,
  input  logic addr_ok,
  input  logic data_ok,
  input  logic mem_mfc,
  output logic busy,
  output logic mem_rd,
  output logic mem_wr,
  output logic done,
  output logic cmd_reject,
  output logic rd_capture
);

  mau_op_t op_q;
  logic    accept;
  logic    refuse;
  logic    finish;

  assign busy       = (op_q != OP_IDLE);
  assign mem_rd     = (op_q == OP_READ);
  assign mem_wr     = (op_q == OP_WRITE);
  assign accept     = !busy && cmd_legal(cmd_read, cmd_write, addr_ok, data_ok);
  assign refuse     = !busy && (cmd_read || cmd_write) && !accept;
  assign finish     = busy && mem_mfc;
  assign rd_capture = finish && mem_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q       <= OP_IDLE;
      done       <= 1'b0;
      cmd_reject <= 1'b0;
    end else begin
      if (finish)      op_q <= OP_IDLE;
      else if (accept) op_q <= op_of(cmd_read, cmd_write);
      done       <= finish;
      cmd_reject <= refuse;
    end
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R3
  accept_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && (mem_rd != mem_wr));
  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_mfc) |=> busy && $stable(mem_rd) && $stable(mem_wr));
  // R6
  finish_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> done && !busy);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> cmd_reject && !busy);
  // R9
  idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> !busy && !done);

endmodule

// File: rtl/mem_access_unit.sv
module mem_access_unit #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              addr_load,
  input  logic              data_load,
  input  logic              cmd_read,
  input  logic              cmd_write,
  input  logic              mem_mfc,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mdr_data,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              busy,
  output logic              done,
  output logic              cmd_reject,
  output logic              load_err
);

  logic addr_ok;
  logic data_ok;
  logic rd_capture;

  mau_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_data   (bus_data),
    .addr_load  (addr_load),
    .data_load  (data_load),
    .busy       (busy),
    .rd_capture (rd_capture),
    .mem_rdata  (mem_rdata),
    .addr_q     (mem_addr),
    .data_q     (mdr_data),
    .addr_ok    (addr_ok),
    .data_ok    (data_ok),
    .load_err   (load_err)
  );

  mau_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_read   (cmd_read),
    .cmd_write  (cmd_write),
    .addr_ok    (addr_ok),
    .data_ok    (data_ok),
    .mem_mfc    (mem_mfc),
    .busy       (busy),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .done       (done),
    .cmd_reject (cmd_reject),
    .rd_capture (rd_capture)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !busy && !done && !cmd_reject && !load_err);

endmodule

// File: tb/mem_access_unit_test.sv
module mem_access_unit_test;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [DW-1:0] bus_data = '0;
  logic          addr_load = 0, data_load = 0, cmd_read = 0, cmd_write = 0;
  logic          stray_mfc = 0;
  logic          model_mfc;
  logic          mem_mfc;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mdr_data;
  logic          mem_rd, mem_wr, busy, done, cmd_reject, load_err;

  int n_chk = 0;
  int n_bad = 0;
  int latency = 0;
  int cnt;
  logic [DW-1:0] mem_arr [16];

  always #5 clk = ~clk;

  assign mem_mfc   = model_mfc | stray_mfc;
  assign mem_rdata = mem_arr[mem_addr[3:0]];

  mem_access_unit #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data),
    .addr_load(addr_load), .data_load(data_load),
    .cmd_read(cmd_read), .cmd_write(cmd_write),
    .mem_mfc(mem_mfc), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mdr_data(mdr_data),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .busy(busy), .done(done),
    .cmd_reject(cmd_reject), .load_err(load_err)
  );

  function automatic logic [DW-1:0] init_word(input int i);
    return DW'(i * 16'h1111) ^ DW'(16'hA5A5);
  endfunction

  // Memory model: completion pulse latency+1 cycles after the strobe rises.
  always @(posedge clk) begin
    if (!rst_n) begin
      model_mfc <= 0;
      cnt <= 0;
      for (int i = 0; i < 16; i++) mem_arr[i] <= init_word(i);
    end else if (model_mfc) begin
      model_mfc <= 0;
      cnt <= 0;
      if (mem_wr) mem_arr[mem_addr[3:0]] <= mdr_data;
    end else if (mem_rd || mem_wr) begin
      if (cnt == latency) model_mfc <= 1;
      else cnt <= cnt + 1;
    end else cnt <= 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic load(input logic la, input logic ld, input logic [DW-1:0] v);
    bus_data = v; addr_load = la; data_load = ld;
    @(negedge clk);
    addr_load = 0; data_load = 0;
  endtask

  // Issues a command, returns busy-cycle count up to the done cycle.
  task automatic run_cmd(input logic rd, input logic wr, input int lat, output int bc);
    int guard;
    latency = lat;
    cmd_read = rd; cmd_write = wr;
    @(negedge clk);
    cmd_read = 0; cmd_write = 0;
    bc = 0; guard = 0;
    while (!done && guard < 200) begin
      if (busy) bc++;
      guard++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 strobes", {mem_rd, mem_wr}, 0);
    chk("R1 reject/err", {cmd_reject, load_err}, 0);
    // not loaded: a read must be refused
    cmd_read = 1; @(negedge clk); cmd_read = 0;
    chk("R1 unloaded read refused", cmd_reject, 1);
  endtask

  task automatic t_write_orders();
    int bc;
    do_reset();
    load(1, 0, 16'h0005);                 // address first
    load(0, 1, 16'hBEEF);
    chk("R2 addr", mem_addr, 16'h0005);
    chk("R2 data", mdr_data, 16'hBEEF);
    latency = 2;
    cmd_write = 1; @(negedge clk); cmd_write = 0;
    chk("R3 busy", busy, 1);
    chk("R3 strobes", {mem_rd, mem_wr}, 2'b01);
    bc = 1;
    while (!done && bc < 200) begin @(negedge clk); if (busy) bc++; end
    chk("R5 busy cycles lat2", bc, 4);
    chk("R6 done", done, 1);
    chk("R3 stored", mem_arr[5], 16'hBEEF);
    @(negedge clk);
    chk("R6 done one cycle", done, 0);
    load(0, 1, 16'h1234);                 // data first
    load(1, 0, 16'h0009);
    run_cmd(0, 1, 0, bc);
    chk("R5 busy cycles lat0", bc, 2);
    chk("R2 data-first write", mem_arr[9], 16'h1234);
    load(1, 1, 16'h000C);                 // same cycle
    chk("R2 same-cycle addr", mem_addr, 16'h000C);
    chk("R2 same-cycle data", mdr_data, 16'h000C);
    run_cmd(0, 1, 5, bc);
    chk("R5 busy cycles lat5", bc, 7);
    chk("R2 same-cycle write", mem_arr[12], 16'h000C);
    chk("R3 strobe dropped", mem_wr, 0);
  endtask

  task automatic t_read();
    int bc;
    load(1, 0, 16'h0003);
    run_cmd(1, 0, 1, bc);
    chk("R4 read data", mdr_data, init_word(3));
    chk("R5 busy cycles lat1", bc, 3);
    chk("R4 strobe dropped", mem_rd, 0);
    load(1, 0, 16'h0009);
    run_cmd(1, 0, 3, bc);
    chk("R4 read back write", mdr_data, 16'h1234);
  endtask

  task automatic t_reject();
    do_reset();
    cmd_write = 1; @(negedge clk); cmd_write = 0;
    chk("R7 write none loaded", {cmd_reject, busy, mem_wr}, 3'b100);
    @(negedge clk);
    chk("R7 reject one cycle", cmd_reject, 0);
    load(1, 0, 16'h0002);
    cmd_write = 1; @(negedge clk); cmd_write = 0;
    chk("R7 write no data", {cmd_reject, busy, mem_wr}, 3'b100);
    load(0, 1, 16'h5555);
    cmd_write = 1; cmd_read = 1; @(negedge clk); cmd_write = 0; cmd_read = 0;
    chk("R7 both cmds", {cmd_reject, busy, mem_rd, mem_wr}, 4'b1000);
  endtask

  task automatic t_busy_ignore();
    int bc;
    do_reset();
    load(1, 1, 16'h0006);
    load(0, 1, 16'h7777);
    latency = 6;
    cmd_write = 1; @(negedge clk); cmd_write = 0;
    @(negedge clk);
    bus_data = 16'h000E; addr_load = 1; data_load = 1;
    @(negedge clk);
    addr_load = 0; data_load = 0;
    chk("R8 load_err set", load_err, 1);
    chk("R8 addr kept", mem_addr, 16'h0006);
    chk("R8 data kept", mdr_data, 16'h7777);
    cmd_read = 1; @(negedge clk); cmd_read = 0;
    chk("R9 busy cmd no reject", cmd_reject, 0);
    chk("R9 strobe unchanged", {mem_rd, mem_wr}, 2'b01);
    bc = 0;
    while (!done && bc < 200) begin @(negedge clk); bc++; end
    chk("R8 stored unchanged", mem_arr[6], 16'h7777);
    chk("R8 load_err sticky", load_err, 1);
    // R10: read issued in the done cycle
    latency = 0;
    cmd_read = 1; @(negedge clk); cmd_read = 0;
    chk("R10 accept in done cycle", {busy, mem_rd}, 2'b11);
    while (!done && bc < 400) begin @(negedge clk); bc++; end
    chk("R10 read result", mdr_data, 16'h7777);
    @(negedge clk);
    stray_mfc = 1; @(negedge clk); stray_mfc = 0;
    chk("R9 stray mfc no busy", busy, 0);
    @(negedge clk);
    chk("R9 stray mfc no done", done, 0);
    chk("R9 stray mfc data", mdr_data, 16'h7777);
  endtask

  initial begin
    t_reset();
    t_write_orders();
    t_read();
    t_reject();
    t_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule